// File: doc/BRIEF.md
# Column Driver with Self-Refresh Frame Store

This block models the digital side of a passive-matrix column driver that keeps a full frame in a private memory. The host streams each row as a series of narrow data words, strobing one word at a time into a row-wide shift register. Host strobes need no fixed cadence, as long as the whole row is in place before the row-load pulse. On each row-load pulse the completed row goes to the column outputs and is written into the frame store at the current row position. A separate physical-row counter lets one logical frame span a panel of fewer rows. With a 240-row frame on a 120-row panel, the panel's first row is flagged twice per frame.

When the host stops sending row-load pulses for a programmable number of cycles, the driver switches by itself to self-refresh. It then produces its own row pulses at a programmable period and replays the stored rows in order, so the panel keeps its image while the host is idle. The next frame-start pulse returns the driver to normal streaming.

Top module: `colRefreshDriver`

## Requirements
- R1: After reset, `colOut`, `rowIndex`, `panelRow`, `firstRow`, `rowStrobe` and `selfRefresh` are all zero.
- R2: Each `latchData` pulse shifts one `BUS_W`-bit word into the row register. After COLS/BUS_W words and a `loadRow` pulse, column c shows bit (c mod BUS_W) of word number (c / BUS_W), where word 0 is the first latched. This is on `colOut` in the cycle after the `loadRow` edge, with `rowStrobe` high for that cycle.
- R3: `rowIndex` on a strobe is the row's position since the last `frameStart`. It returns to 0 after `cfgRowCount` rows, and a `frameStart` in normal mode restarts it at 0.
- R4: `panelRow` counts strobes modulo `cfgPanelRows` and restarts at `frameStart`. `firstRow` is high together with `rowStrobe` exactly when `panelRow` is 0.
- R5: Once at least one row has been loaded since reset, `selfRefresh` rises exactly `cfgIdleLimit` cycles after the last `loadRow` or `frameStart` edge. It never rises before the first row load after reset.
- R6: In self-refresh, `rowStrobe` pulses every `cfgRefreshPeriod` cycles, the first one `cfgRefreshPeriod` cycles after entry. Rows are replayed from index 0 upward with the same wrap and panel rules as R3/R4, and `colOut` shows the last data written to that row.
- R7: A `loadRow` in self-refresh produces no strobe and does not change the frame store.
- R8: A `frameStart` in self-refresh clears `selfRefresh` on the next edge, and the next row loaded is row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Frame-start pulse |
| latchData | input | 1 | Shift one data word into the row register |
| dataIn | input | BUS_W | Data word |
| loadRow | input | 1 | Commit row register to outputs and store |
| cfgRowCount | input | ROW_W | Logical rows per frame (1..ROWS) |
| cfgPanelRows | input | ROW_W | Physical rows of the panel |
| cfgIdleLimit | input | TMR_W | Idle cycles before self-refresh |
| cfgRefreshPeriod | input | TMR_W | Cycles between self-refresh rows |
| colOut | output | COLS | Column data of the current row |
| rowIndex | output | ROW_W | Logical row of the current strobe |
| panelRow | output | ROW_W | Physical row of the current strobe |
| firstRow | output | 1 | Strobe is for physical row 0 |
| rowStrobe | output | 1 | One-cycle row pulse |
| selfRefresh | output | 1 | Driver is replaying from its store |

## Verification
The bench builds the block with 16 columns, an 8-row store, 4-bit words and 8-bit timers. With these values a row takes four latches, and a full store fill, the row-pointer wrap and several replay wraps all finish within a few hundred cycles. A panel of 4 rows under an 8-row frame produces two first-row flags per frame. Random row counts, periods and idle limits then cover uneven wraps, such as 6 rows with 9 loads, and short refresh periods.

// File: rtl/colDrvPkg.sv
package colDrvPkg;
  typedef struct packed {
    logic writeRow;   // commit shift register to outputs and store
    logic replayRow;  // present a stored row during self-refresh
  } rowCmd_t;
endpackage

// File: rtl/colDrvCtrl.sv
module colDrvCtrl
  import colDrvPkg::*;
#(
  parameter int ROWS  = 240,
  parameter int TMR_W = 16,
  parameter int ROW_W = $clog2(ROWS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             loadRow,
  input  logic [ROW_W-1:0] cfgRowCount,
  input  logic [ROW_W-1:0] cfgPanelRows,
  input  logic [TMR_W-1:0] cfgIdleLimit,
  input  logic [TMR_W-1:0] cfgRefreshPeriod,
  output rowCmd_t          cmd,
  output logic [ROW_W-1:0] rowAddr,
  output logic [ROW_W-1:0] panelAddr,
  output logic             selfMode
);
  localparam logic [ROW_W:0] ONE_R = 1;
  localparam logic [TMR_W:0] ONE_T = 1;

  logic [ROW_W-1:0] rowPtr, panelPtr, rowLimit, panelLimit;
  logic [ROW_W-1:0] baseRow, basePanel, nextRow, nextPanel;
  logic [ROW_W:0]   rowInc, panelInc;
  logic [TMR_W-1:0] idleCnt, refTimer;
  logic             armed, refTick, goIdle;

  always_comb begin
    if (cfgRowCount == '0)                 rowLimit = ROW_W'(1);
    else if (cfgRowCount > ROW_W'(ROWS))   rowLimit = ROW_W'(ROWS);
    else                                   rowLimit = cfgRowCount;
    panelLimit = (cfgPanelRows == '0) ? ROW_W'(1) : cfgPanelRows;
  end

  // A frame start in normal mode restarts both counters for this cycle's load
  assign baseRow   = (frameStart && !selfMode) ? '0 : rowPtr;
  assign basePanel = (frameStart && !selfMode) ? '0 : panelPtr;
  assign rowInc    = {1'b0, baseRow} + ONE_R;
  assign panelInc  = {1'b0, basePanel} + ONE_R;
  assign nextRow   = (rowInc >= {1'b0, rowLimit}) ? '0 : rowInc[ROW_W-1:0];
  assign nextPanel = (panelInc >= {1'b0, panelLimit}) ? '0 : panelInc[ROW_W-1:0];

  assign refTick = ({1'b0, refTimer} + ONE_T) >= {1'b0, cfgRefreshPeriod};
  assign goIdle  = armed && !selfMode && !loadRow && !frameStart &&
                   (({1'b0, idleCnt} + ONE_T) >= {1'b0, cfgIdleLimit});

  assign cmd.writeRow  = loadRow && !selfMode;
  assign cmd.replayRow = selfMode && !frameStart && refTick;
  assign rowAddr   = baseRow;
  assign panelAddr = basePanel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selfMode <= 1'b0;
      armed    <= 1'b0;
      rowPtr   <= '0;
      panelPtr <= '0;
      idleCnt  <= '0;
      refTimer <= '0;
    end else if (selfMode) begin
      idleCnt <= '0;
      if (frameStart) begin
        selfMode <= 1'b0;
        rowPtr   <= '0;
        panelPtr <= '0;
        refTimer <= '0;
      end else if (refTick) begin
        refTimer <= '0;
        rowPtr   <= nextRow;
        panelPtr <= nextPanel;
      end else begin
        refTimer <= refTimer + 1'b1;
      end
    end else begin
      refTimer <= '0;
      if (loadRow) begin
        rowPtr   <= nextRow;
        panelPtr <= nextPanel;
        armed    <= 1'b1;
        idleCnt  <= '0;
      end else if (frameStart) begin
        rowPtr   <= '0;
        panelPtr <= '0;
        idleCnt  <= '0;
      end else if (goIdle) begin
        selfMode <= 1'b1;
        rowPtr   <= '0;
        panelPtr <= '0;
        idleCnt  <= '0;
      end else if (armed) begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  assert_exit_on_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    selfMode && frameStart |=> !selfMode);

  assert_frame_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    frameStart && !loadRow |=> rowPtr == '0);

  assert_idle_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selfMode) |-> $past(armed && !loadRow && !frameStart));
endmodule

// File: rtl/colDrvData.sv
module colDrvData
  import colDrvPkg::*;
#(
  parameter int COLS  = 160,
  parameter int ROWS  = 240,
  parameter int BUS_W = 4,
  parameter int ROW_W = $clog2(ROWS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             latchData,
  input  logic [BUS_W-1:0] dataIn,
  input  rowCmd_t          cmd,
  input  logic [ROW_W-1:0] rowAddr,
  input  logic [ROW_W-1:0] panelAddr,
  output logic [COLS-1:0]  colOut,
  output logic [ROW_W-1:0] rowIndex,
  output logic [ROW_W-1:0] panelRow,
  output logic             firstRow,
  output logic             rowStrobe
);
  localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [COLS-1:0] shiftReg;
  logic [COLS-1:0] store [ROWS];
  logic [COLS-1:0] readRow;

  // Words enter at the top and move down, so the first word ends at column 0
  generate
    if (COLS > BUS_W) begin : gWide
      always_ff @(posedge clk) begin
        if (!rstN)          shiftReg <= '0;
        else if (latchData) shiftReg <= {dataIn, shiftReg[COLS-1:BUS_W]};
      end
    end else begin : gNarrow
      always_ff @(posedge clk) begin
        if (!rstN)          shiftReg <= '0;
        else if (latchData) shiftReg <= dataIn[COLS-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (cmd.writeRow) store[rowAddr[IDX_W-1:0]] <= shiftReg;
  end

  assign readRow = store[rowAddr[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colOut    <= '0;
      rowIndex  <= '0;
      panelRow  <= '0;
      firstRow  <= 1'b0;
      rowStrobe <= 1'b0;
    end else begin
      rowStrobe <= cmd.writeRow || cmd.replayRow;
      firstRow  <= (cmd.writeRow || cmd.replayRow) && (panelAddr == '0);
      if (cmd.writeRow || cmd.replayRow) begin
        colOut   <= cmd.writeRow ? shiftReg : readRow;
        rowIndex <= rowAddr;
        panelRow <= panelAddr;
      end
    end
  end

  assert_single_cmd_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.writeRow, cmd.replayRow}));

  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.writeRow || cmd.replayRow) |=> rowStrobe);

  assert_no_stray_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.writeRow || cmd.replayRow) |=> !rowStrobe && !firstRow);
endmodule

// File: rtl/colRefreshDriver.sv
module colRefreshDriver
  import colDrvPkg::*;
#(
  parameter int COLS  = 160,
  parameter int ROWS  = 240,
  parameter int BUS_W = 4,
  parameter int TMR_W = 16,
  parameter int ROW_W = $clog2(ROWS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             latchData,
  input  logic [BUS_W-1:0] dataIn,
  input  logic             loadRow,
  input  logic [ROW_W-1:0] cfgRowCount,
  input  logic [ROW_W-1:0] cfgPanelRows,
  input  logic [TMR_W-1:0] cfgIdleLimit,
  input  logic [TMR_W-1:0] cfgRefreshPeriod,
  output logic [COLS-1:0]  colOut,
  output logic [ROW_W-1:0] rowIndex,
  output logic [ROW_W-1:0] panelRow,
  output logic             firstRow,
  output logic             rowStrobe,
  output logic             selfRefresh
);
  rowCmd_t          cmd;
  logic [ROW_W-1:0] rowAddr, panelAddr;

  colDrvCtrl #(.ROWS(ROWS), .TMR_W(TMR_W), .ROW_W(ROW_W)) uCtrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .loadRow(loadRow),
    .cfgRowCount(cfgRowCount), .cfgPanelRows(cfgPanelRows),
    .cfgIdleLimit(cfgIdleLimit), .cfgRefreshPeriod(cfgRefreshPeriod),
    .cmd(cmd), .rowAddr(rowAddr), .panelAddr(panelAddr), .selfMode(selfRefresh)
  );

  colDrvData #(.COLS(COLS), .ROWS(ROWS), .BUS_W(BUS_W), .ROW_W(ROW_W)) uData (
    .clk(clk), .rstN(rstN), .latchData(latchData), .dataIn(dataIn),
    .cmd(cmd), .rowAddr(rowAddr), .panelAddr(panelAddr),
    .colOut(colOut), .rowIndex(rowIndex), .panelRow(panelRow),
    .firstRow(firstRow), .rowStrobe(rowStrobe)
  );

  assert_strobe_only_replay_R7: assert property (@(posedge clk) disable iff (!rstN)
    selfRefresh && $past(selfRefresh) && rowStrobe |-> $past(cmd.replayRow));
endmodule

// File: tb/tb_colRefreshDriver.sv
module tb_colRefreshDriver;
  localparam int COLS = 16, ROWS = 8, BW = 4, TW = 8;
  localparam int RW = $clog2(ROWS + 1);
  localparam int NW = COLS / BW;

  logic clk = 1'b0, rstN = 1'b0;
  logic frameStart = 0, latchData = 0, loadRow = 0;
  logic [BW-1:0] dataIn = '0;
  logic [RW-1:0] cfgRowCount, cfgPanelRows;
  logic [TW-1:0] cfgIdleLimit, cfgRefreshPeriod;
  logic [COLS-1:0] colOut;
  logic [RW-1:0] rowIndex, panelRow;
  logic firstRow, rowStrobe, selfRefresh;

  int tests = 0, fails = 0;
  logic [COLS-1:0] model [ROWS];
  int ePtr = 0, ePanel = 0;

  always #2 clk = ~clk;

  colRefreshDriver #(.COLS(COLS), .ROWS(ROWS), .BUS_W(BW), .TMR_W(TW)) dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .latchData(latchData),
    .dataIn(dataIn), .loadRow(loadRow), .cfgRowCount(cfgRowCount),
    .cfgPanelRows(cfgPanelRows), .cfgIdleLimit(cfgIdleLimit),
    .cfgRefreshPeriod(cfgRefreshPeriod), .colOut(colOut), .rowIndex(rowIndex),
    .panelRow(panelRow), .firstRow(firstRow), .rowStrobe(rowStrobe),
    .selfRefresh(selfRefresh)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wrapInc(input int v, input int lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  task automatic advance();
    ePtr   = wrapInc(ePtr, int'(cfgRowCount));
    ePanel = wrapInc(ePanel, int'(cfgPanelRows));
  endtask

  task automatic startFrame();
    @(negedge clk); frameStart = 1;
    @(negedge clk); frameStart = 0;
    ePtr = 0; ePanel = 0;
    check(selfRefresh == 1'b0, "R8 frame start leaves refresh", 64'(selfRefresh), 0);
  endtask

  // R2/R3/R4: latch words with random gaps, then load and compare
  task automatic sendRow(input logic [COLS-1:0] d);
    for (int k = 0; k < NW; k++) begin
      @(negedge clk); dataIn = d[k*BW +: BW]; latchData = 1;
      @(negedge clk); latchData = 0; dataIn = $urandom;
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    @(negedge clk); loadRow = 1;
    @(negedge clk); loadRow = 0;
    check(rowStrobe == 1'b1, "R2 strobe on load", 64'(rowStrobe), 1);
    check(colOut == d, "R2 column order", 64'(colOut), 64'(d));
    check(int'(rowIndex) == ePtr, "R3 row index", 64'(rowIndex), 64'(ePtr));
    check(int'(panelRow) == ePanel && firstRow == (ePanel == 0),
          "R4 panel row/first flag", {32'(panelRow), 31'd0, firstRow},
          {32'(ePanel), 31'd0, ePanel == 0});
    model[ePtr] = d;
    advance();
  endtask

  // R5: count cycles from the last load edge to self-refresh entry
  task automatic waitIdle();
    int k = 0;
    while (!selfRefresh && k < int'(cfgIdleLimit) + 10) begin
      @(negedge clk); k++;
    end
    check(k == int'(cfgIdleLimit), "R5 idle entry delay", 64'(k), 64'(cfgIdleLimit));
    ePtr = 0; ePanel = 0;
  endtask

  // R6/R7: replay n rows, optionally injecting a load during row injectAt
  task automatic replay(input int n, input int injectAt);
    for (int r = 0; r < n; r++) begin
      int stray = 0;
      for (int i = 1; i <= int'(cfgRefreshPeriod); i++) begin
        if (r == injectAt && i == 1) begin loadRow = 1; latchData = 1; dataIn = 4'hA; end
        @(negedge clk);
        loadRow = 0; latchData = 0;
        if (r == injectAt && i == 1)
          check(rowStrobe == 1'b0, "R7 load ignored in refresh", 64'(rowStrobe), 0);
        if (i < int'(cfgRefreshPeriod) && rowStrobe) stray++;
      end
      check(stray == 0 && rowStrobe, "R6 refresh period", {32'(stray), 31'd0, rowStrobe}, 1);
      check(colOut == model[ePtr], "R6 replay data", 64'(colOut), 64'(model[ePtr]));
      check(int'(rowIndex) == ePtr && int'(panelRow) == ePanel && firstRow == (ePanel == 0),
            "R6 replay order", {32'(rowIndex), 32'(panelRow)}, {32'(ePtr), 32'(ePanel)});
      advance();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    cfgRowCount = 8; cfgPanelRows = 4; cfgIdleLimit = 40; cfgRefreshPeriod = 6;
    repeat (3) @(negedge clk);
    rstN = 1;
    check(colOut == '0 && rowIndex == '0 && panelRow == '0 && !firstRow && !rowStrobe
          && !selfRefresh, "R1 reset state", 64'(colOut), 0);
    repeat (int'(cfgIdleLimit) + 5) @(negedge clk);
    check(selfRefresh == 1'b0, "R5 no refresh before first row", 64'(selfRefresh), 0);

    // Directed: 8-row frame on a 4-row panel, double first-row flag
    startFrame();
    sendRow(16'h4321);
    sendRow(16'hFFFF);
    sendRow(16'h0000);
    for (int r = 3; r < 8; r++) sendRow(COLS'($urandom));
    waitIdle();
    replay(10, 2);
    startFrame();

    // Mid-frame restart, then wrap with overwrite on a 6-row frame
    cfgRowCount = 6; cfgPanelRows = 6; cfgIdleLimit = 25; cfgRefreshPeriod = 5;
    startFrame();
    sendRow(COLS'($urandom));
    sendRow(COLS'($urandom));
    startFrame();
    for (int r = 0; r < 9; r++) sendRow(COLS'($urandom));
    waitIdle();
    replay(7, -1);
    startFrame();
    sendRow(16'h5A5A);
    check(model[0] == 16'h5A5A, "R8 first row after exit is row 0", 64'(model[0]), 16'h5A5A);

    // Random configurations
    for (int t = 0; t < 4; t++) begin
      int rc = $urandom_range(1, ROWS);
      cfgRowCount = RW'(rc);
      cfgPanelRows = RW'($urandom_range(1, rc));
      cfgRefreshPeriod = TW'($urandom_range(2, 7));
      cfgIdleLimit = TW'($urandom_range(20, 40));
      startFrame();
      for (int r = 0; r < rc + $urandom_range(0, 3); r++) sendRow(COLS'($urandom));
      waitIdle();
      replay(rc + 1, (t == 0) ? 0 : -1);
      startFrame();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule